// File: doc/BRIEF.md
# LPC host cycle splitter

This block sits on the host side of a Low Pin Count bus. A requester hands it one parallel access: an address, write data, a byte size of one, two or four, a read/write flag and a memory/I/O flag. The block turns that access into single-byte LPC cycles on a 4-bit multiplexed data bus framed by an active-low frame strobe. A two-byte request becomes two back-to-back byte cycles and a four-byte request becomes four, with the byte addresses ascending.

Each byte cycle has the same phases. First comes a start nibble, then a type nibble, then the address. A write adds its data here. Two turnaround clocks follow, then the host waits for the peripheral's SYNC handshake, and a read then receives its data. Read bytes are packed little-endian into the returned word. A transfer can fail in two ways: nobody answers SYNC within the timeout, or the peripheral signals an error. In either case the host drives an abort frame, skips the bytes that are still pending, and returns all-ones data with an abort flag. The requester sees one completion pulse per request.

Top module: `lpc_host_splitter`

## Requirements
- R1: `req_ready_o` is high only while the block is idle. A request is taken when `req_valid_i` and `req_ready_o` are both high, and `req_ready_o` is low from the next cycle until the completion pulse.
- R2: Every byte cycle opens with exactly one clock of `lframe_no` low and `lad_o` = 4'b0000. The next clock carries the type nibble {0, mem, write, 0}: I/O read 0000, I/O write 0010, memory read 0100, memory write 0110.
- R3: The address follows the type nibble, most significant nibble first. A memory cycle sends eight nibbles of the 32-bit byte address. An I/O cycle sends four nibbles, carrying bits 15:0 of that address.
- R4: Write data is sent as two nibbles, bits 3:0 first and then bits 7:4.
- R5: `req_size_i` encodes 0 as one byte, 1 as two bytes and 2 or 3 as four bytes. Byte i of a request is a separate LPC cycle at address `req_addr_i`+i, with i ascending from 0.
- R6: After the host phase, the block drives 1111 for one clock and releases LAD (`lad_oe_o` low) for the next. It then samples SYNC.
- R7: The SYNC value 0000 means ready. A wait value (0101 or 0110) holds the cycle and restarts the timeout, so waits of any length are allowed.
- R8: Any other SYNC value except 1010 counts as a miss. Four consecutive misses make the cycle unclaimed. A ready that arrives on the fourth SYNC sample is still a claim.
- R9: A SYNC value of 1010 (error) ends the request through the same abort path as an unclaimed cycle.
- R10: On abort, the block drives `lframe_no` low with `lad_o` = 1111 for exactly 4 clocks. No further byte cycle of that request is started. The completion carries `abort_o` = 1 and `rdata_o` = all ones.
- R11: On a successful read, byte i is placed at `rdata_o[8i+7:8i]` and the unused upper lanes are zero. A successful write returns zero.
- R12: `done_o` pulses for one clock after the last byte cycle has finished (after its two closing turnaround clocks) or after the abort frame. Reset, including reset in mid-cycle, leaves `lframe_no` high, `lad_oe_o` low, `req_ready_o` high and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | LPC clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mem_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_size_i | input | 2 | Byte count code: 0 = 1, 1 = 2, 2/3 = 4 |
| req_addr_i | input | 32 | Byte address of the first byte |
| req_wdata_i | input | 32 | Write data, byte i in lane i |
| done_o | output | 1 | One-clock completion pulse |
| abort_o | output | 1 | Request was aborted (valid with done_o) |
| rdata_o | output | 32 | Read data (valid with done_o) |
| lframe_no | output | 1 | Frame strobe, active low |
| lad_o | output | 4 | LAD value driven by the host |
| lad_oe_o | output | 1 | Host drives LAD when high |
| lad_i | input | 4 | LAD value seen on the bus |

## Verification
Two functions can land on the same clock. One is the SYNC timeout reaching its final count. The other is the peripheral's ready code arriving on that very sample. The bench provokes this by holding the bus idle for three SYNC samples and then answering ready. It judges the result by requiring a normal completion with the peer's data and no abort frame. Beside that case, four idle samples and an error code in the middle of a split request check that the abort frame lasts four clocks, that no later byte cycle starts, and that all-ones data comes back with a single completion pulse.

// File: rtl/lpc_split_pkg.sv
package lpc_split_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_CTDIR, PH_ADDR, PH_WDATA, PH_TAR_DRV,
    PH_TAR_REL, PH_SYNC, PH_RDATA, PH_TAR_END, PH_ABORT
  } phase_e;

  localparam logic [3:0] NIB_START  = 4'h0;
  localparam logic [3:0] NIB_ONES   = 4'hF;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_SHORT = 4'h5;
  localparam logic [3:0] SYNC_LONG  = 4'h6;
  localparam logic [3:0] SYNC_ERR   = 4'hA;
endpackage

// File: rtl/lpc_sync_watch.sv
module lpc_sync_watch
  import lpc_split_pkg::*;
#(
  parameter int TIMEOUT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic [3:0] lad_i,
  output logic       ready_o,
  output logic       fail_o
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] miss_q;
  logic is_wait, known, miss;

  assign is_wait = (lad_i == SYNC_SHORT) || (lad_i == SYNC_LONG);
  assign known   = is_wait || (lad_i == SYNC_READY) || (lad_i == SYNC_ERR);
  assign miss    = active_i && !known;
  assign ready_o = active_i && (lad_i == SYNC_READY);
  assign fail_o  = active_i && ((lad_i == SYNC_ERR) ||
                                (miss && miss_q == TW'(TIMEOUT - 1)));

  // consecutive misses only; a wait or any exit restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                miss_q <= '0;
    else if (miss && !fail_o)   miss_q <= miss_q + 1'b1;
    else                        miss_q <= '0;
  end

  AST_MISS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q < TW'(TIMEOUT)); // R8
  AST_WAIT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && is_wait) |=> (miss_q == '0)); // R7
endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
  import lpc_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CW     = 3
) (
  input  phase_e            ph_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [ADDR_W-1:0] baddr_i,
  input  logic [7:0]        wbyte_i,
  input  logic              wr_i,
  input  logic              mem_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  output logic              lframe_no
);
  localparam int NW = $clog2(ADDR_W / 4);

  logic [NW-1:0] nib;
  assign nib = NW'(cnt_i);

  always_comb begin
    lad_o     = NIB_ONES;
    lad_oe_o  = 1'b1;
    lframe_no = 1'b1;
    unique case (ph_i)
      PH_START:   begin lad_o = NIB_START; lframe_no = 1'b0; end
      PH_CTDIR:   lad_o = {1'b0, mem_i, wr_i, 1'b0};
      PH_ADDR:    lad_o = baddr_i[{nib, 2'b00} +: 4];
      PH_WDATA:   lad_o = cnt_i[0] ? wbyte_i[7:4] : wbyte_i[3:0];
      PH_TAR_DRV: lad_o = NIB_ONES;
      PH_ABORT:   lframe_no = 1'b0;
      default:    lad_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpc_rd_gather.sv
module lpc_rd_gather #(
  parameter int LANES = 4,
  parameter int LW    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               fill_i,
  input  logic               cap_i,
  input  logic [LW-1:0]      lane_i,
  input  logic               hi_i,
  input  logic [3:0]         nib_i,
  output logic [8*LANES-1:0] word_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           byte_q <= '0;
      else if (clear_i)                      byte_q <= '0;
      else if (fill_i)                       byte_q <= 8'hFF;
      else if (cap_i && lane_i == LW'(g)) begin
        if (hi_i) byte_q[7:4] <= nib_i;
        else      byte_q[3:0] <= nib_i;
      end
    end
    assign word_o[8*g +: 8] = byte_q;
  end
endmodule

// File: rtl/lpc_host_splitter.sv
module lpc_host_splitter
  import lpc_split_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int TIMEOUT_CLKS = 4,
  parameter int ABORT_CLKS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_mem_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic              abort_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              lframe_no,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  input  logic [3:0]        lad_i
);
  localparam int NBYTES  = DATA_W / 8;
  localparam int LW      = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int CNT_MAX = (ABORT_CLKS > 8) ? ABORT_CLKS : 8;
  localparam int CW      = $clog2(CNT_MAX);
  localparam int MEM_NIB = ADDR_W / 4;
  localparam int IO_NIB  = 4;

  phase_e            ph_q;
  logic [CW-1:0]     cnt_q;
  logic [LW-1:0]     bidx_q, last_q;
  logic [ADDR_W-1:0] addr_q, baddr;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q, mem_q, done_q, abort_q;
  logic              sync_ready, sync_fail, accept;
  logic [7:0]        wbyte;

  assign accept      = req_valid_i && (ph_q == PH_IDLE);
  assign req_ready_o = (ph_q == PH_IDLE);
  assign baddr       = addr_q + ADDR_W'(bidx_q);
  assign wbyte       = wdata_q[{bidx_q, 3'b000} +: 8];
  assign done_o      = done_q;
  assign abort_o     = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      last_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      mem_q   <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (accept) begin
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          wr_q    <= req_write_i;
          mem_q   <= req_mem_i;
          bidx_q  <= '0;
          unique case (req_size_i)
            2'd0:    last_q <= '0;
            2'd1:    last_q <= LW'(1);
            default: last_q <= LW'(NBYTES - 1);
          endcase
          ph_q <= PH_START;
        end
        PH_START: ph_q <= PH_CTDIR;
        PH_CTDIR: begin
          cnt_q <= mem_q ? CW'(MEM_NIB - 1) : CW'(IO_NIB - 1);
          ph_q  <= PH_ADDR;
        end
        PH_ADDR: begin
          if (cnt_q == '0) ph_q <= wr_q ? PH_WDATA : PH_TAR_DRV;
          else             cnt_q <= cnt_q - 1'b1;
        end
        PH_WDATA: begin
          if (cnt_q[0]) begin cnt_q <= '0; ph_q <= PH_TAR_DRV; end
          else          cnt_q <= cnt_q + 1'b1;
        end
        PH_TAR_DRV: ph_q <= PH_TAR_REL;
        PH_TAR_REL: ph_q <= PH_SYNC;
        PH_SYNC: begin
          cnt_q <= '0;
          if (sync_fail)       ph_q <= PH_ABORT;
          else if (sync_ready) ph_q <= wr_q ? PH_TAR_END : PH_RDATA;
        end
        PH_RDATA: begin
          if (cnt_q[0]) begin cnt_q <= '0; ph_q <= PH_TAR_END; end
          else          cnt_q <= cnt_q + 1'b1;
        end
        PH_TAR_END: begin
          if (cnt_q[0]) begin
            cnt_q <= '0;
            if (bidx_q == last_q) begin
              ph_q    <= PH_IDLE;
              done_q  <= 1'b1;
              abort_q <= 1'b0;
            end else begin
              bidx_q <= bidx_q + 1'b1;
              ph_q   <= PH_START;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_ABORT: begin
          if (cnt_q == CW'(ABORT_CLKS - 1)) begin
            cnt_q   <= '0;
            ph_q    <= PH_IDLE;
            done_q  <= 1'b1;
            abort_q <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  lpc_sync_watch #(.TIMEOUT(TIMEOUT_CLKS)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (ph_q == PH_SYNC),
    .lad_i    (lad_i),
    .ready_o  (sync_ready),
    .fail_o   (sync_fail)
  );

  lpc_lad_drive #(.ADDR_W(ADDR_W), .CW(CW)) u_drive (
    .ph_i      (ph_q),
    .cnt_i     (cnt_q),
    .baddr_i   (baddr),
    .wbyte_i   (wbyte),
    .wr_i      (wr_q),
    .mem_i     (mem_q),
    .lad_o     (lad_o),
    .lad_oe_o  (lad_oe_o),
    .lframe_no (lframe_no)
  );

  lpc_rd_gather #(.LANES(NBYTES), .LW(LW)) u_gather (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .fill_i  (sync_fail),
    .cap_i   (ph_q == PH_RDATA),
    .lane_i  (bidx_q),
    .hi_i    (cnt_q[0]),
    .nib_i   (lad_i),
    .word_o  (rdata_o)
  );

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R1
  AST_START_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lframe_no && lad_o == NIB_START) |=> (lframe_no && lad_oe_o)); // R2
  AST_BYTE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != PH_IDLE) |-> (bidx_q <= last_q)); // R5
  AST_TAR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_TAR_DRV) |=> !lad_oe_o); // R6
  AST_ABORT_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && abort_o) |-> (rdata_o == '1)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
endmodule

// File: tb/lpc_host_splitter_bench.sv
module lpc_host_splitter_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic        mem;
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  mode;   // 0 claimed, 1 silent, 2 error SYNC
    logic [1:0]  fbyte;  // byte index that fails
    logic [2:0]  pre;    // idle SYNC samples before answer
    logic [2:0]  waits;  // wait codes before ready
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd0, 32'h0000_12F0, 32'h0000_0000, 2'd0, 2'd0, 3'd0, 3'd0},
    '{1'b1, 1'b0, 2'd1, 32'h0000_03F8, 32'h0000_BEEF, 2'd0, 2'd0, 3'd0, 3'd1},
    '{1'b0, 1'b1, 2'd2, 32'h000F_FFFE, 32'h0000_0000, 2'd0, 2'd0, 3'd1, 3'd1},
    '{1'b1, 1'b1, 2'd2, 32'h00C8_0000, 32'h1122_3344, 2'd0, 2'd0, 3'd3, 3'd7},
    '{1'b0, 1'b0, 2'd1, 32'h0000_0060, 32'h0000_0000, 2'd0, 2'd0, 3'd3, 3'd0},
    '{1'b0, 1'b1, 2'd2, 32'h0000_0100, 32'h0000_0000, 2'd1, 2'd2, 3'd0, 3'd0},
    '{1'b1, 1'b0, 2'd1, 32'h0000_0080, 32'h0000_A5A5, 2'd2, 2'd0, 3'd0, 3'd0},
    '{1'b0, 1'b1, 2'd0, 32'h0020_0000, 32'h0000_0000, 2'd1, 2'd0, 3'd0, 3'd0},
    '{1'b0, 1'b0, 2'd3, 32'h0001_FFFF, 32'h0000_0000, 2'd0, 2'd0, 3'd2, 3'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  lad_in = 4'hF;
  logic        req_ready, done, abort_f, lframe_n, lad_oe;
  logic [31:0] rdata;
  logic [3:0]  lad_out;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lpc_host_splitter u_lpc_host_splitter (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_mem_i(req_mem), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .done_o(done), .abort_o(abort_f), .rdata_o(rdata),
    .lframe_no(lframe_n), .lad_o(lad_out), .lad_oe_o(lad_oe), .lad_i(lad_in)
  );

  function automatic logic [31:0] eaddr(logic mem, logic [31:0] a, int i);
    logic [31:0] s;
    s = a + 32'(i);
    return mem ? s : {16'h0, s[15:0]};
  endfunction

  function automatic logic [7:0] rbyte(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // peripheral side of one byte cycle; entered and left on a falling edge
  task automatic serve_byte(input vec_t v, input int i);
    int n = 0;
    logic [31:0] a = '0;
    logic [3:0] lo, hi;
    logic [7:0] b;
    while (!(!lframe_n && lad_oe && lad_out == 4'h0) && n < 60) begin
      @(negedge clk); n++;
    end
    chk(n < 60, "R5 byte cycle start", 32'(n), 32'd0);
    if (n >= 60) return;
    @(negedge clk);
    chk(lframe_n && lad_out == {1'b0, v.mem, v.wr, 1'b0}, "R2 type nibble",
        {28'h0, lad_out}, {28'h0, 1'b0, v.mem, v.wr, 1'b0});
    for (int k = 0; k < (v.mem ? 8 : 4); k++) begin
      @(negedge clk);
      a = {a[27:0], lad_out};
    end
    chk(a == eaddr(v.mem, v.addr, i), "R3 R5 byte address", a, eaddr(v.mem, v.addr, i));
    if (v.wr) begin
      @(negedge clk); lo = lad_out;
      @(negedge clk); hi = lad_out;
      chk({hi, lo} == v.wdata[8*i +: 8], "R4 write byte", {24'h0, hi, lo},
          {24'h0, v.wdata[8*i +: 8]});
    end
    @(negedge clk);
    chk(lad_oe && lad_out == 4'hF, "R6 turnaround drive", {27'h0, lad_oe, lad_out}, 32'h1F);
    @(negedge clk);
    chk(!lad_oe, "R6 turnaround release", {31'h0, lad_oe}, 32'h0);
    @(negedge clk);
    if (v.mode == 2'd1 && i == int'(v.fbyte)) return;
    if (v.mode == 2'd2 && i == int'(v.fbyte)) begin
      lad_in = 4'hA; @(negedge clk); lad_in = 4'hF;
      return;
    end
    repeat (v.pre) @(negedge clk);
    repeat (v.waits) begin lad_in = 4'h6; @(negedge clk); end
    lad_in = 4'h0;
    @(negedge clk);
    if (!v.wr) begin
      b = rbyte(eaddr(v.mem, v.addr, i));
      lad_in = b[3:0]; @(negedge clk);
      lad_in = b[7:4]; @(negedge clk);
    end
    lad_in = 4'hF;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int nb, last, n, ab;
    bit fail;
    logic [31:0] exp;
    nb   = (v.size == 2'd0) ? 1 : (v.size == 2'd1) ? 2 : 4;
    fail = (v.mode != 2'd0);
    last = fail ? int'(v.fbyte) : nb - 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_mem = v.mem; req_size = v.size;
    req_addr = v.addr; req_wdata = v.wdata;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1 busy after accept", {31'h0, req_ready}, 32'h0);
    for (int i = 0; i <= last; i++) serve_byte(v, i);
    n = 0; ab = 0;
    forever begin
      if (!lframe_n && lad_oe && lad_out == 4'hF) ab++;
      chk(!(!lframe_n && lad_out == 4'h0), "R10 no cycle after last", 32'(idx), 32'hFFFF);
      if (done || n > 300) break;
      @(negedge clk); n++;
    end
    chk(done, "R12 completion pulse", {31'h0, done}, 32'h1);
    chk(abort_f == fail, "R10 R8 R9 abort flag", {31'h0, abort_f}, {31'h0, fail});
    chk(ab == (fail ? 4 : 0), "R10 abort frame length", 32'(ab), fail ? 32'd4 : 32'd0);
    if (fail) exp = '1;
    else begin
      exp = '0;
      if (!v.wr) for (int i = 0; i < nb; i++) exp[8*i +: 8] = rbyte(eaddr(v.mem, v.addr, i));
    end
    chk(rdata == exp, fail ? "R10 all-ones data" : "R11 packed data", rdata, exp);
    chk(req_ready, "R1 ready at completion", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    chk(!done, "R12 single pulse", {31'h0, done}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(lframe_n && !lad_oe && req_ready && !done, "R12 reset state",
        {28'h0, lframe_n, lad_oe, req_ready, done}, 32'hA);
    rst_n = 1'b1;
    // table walk; vector 4 is the timeout/ready tie, 3 the long wait (R7, R8)
    for (int v = 0; v < NV; v++) run_vec(VECS[v], v);
    // R12: reset in the middle of an address phase
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_mem = 1'b1; req_size = 2'd2; req_addr = 32'h44;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(lframe_n && !lad_oe && req_ready && !done, "R12 reset mid-cycle",
        {28'h0, lframe_n, lad_oe, req_ready, done}, 32'hA);
    @(negedge clk);
    rst_n = 1'b1;
    run_vec(VECS[0], 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule